// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM whose read and write data both travel on the data bus two clock cycles after the command that asks for them. Because the two directions share that one latency, a controller can mix reads and writes on consecutive cycles and the bus never needs an idle cycle to change direction. Words are built from 9-bit byte lanes, and each lane has its own active-low write enable. A two-bit burst counter lets a single loaded address be followed by up to three continue cycles in linear or interleaved order.

The shared bidirectional bus is presented as a pad-ready split. `dq_out` and `dq_oe` drive the pad, and `dq_in` returns what is on the pad. `dq_oe` low stands for the high-impedance state. An active edge is a rising clock edge with `clk_en_n` low and `sleep` low. All timing below counts active edges only. The bus slot of a command accepted at active edge E is the interval from active edge E+2 to active edge E+3. A read drives its word throughout its slot. A write takes its word from `dq_in` at edge E+3, which closes the slot. Every interface here is a fixed-latency bus with no back-pressure, so no valid/ready handshake exists. A controller paces itself purely by counting active edges.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_n` is low, and until the first command accepted after reset reaches its bus slot, `dq_oe` is 0. Reset also ends any burst. Memory contents are not cleared.
- R2: At an active edge with `adv_ld` = 0 and the chip selected (`sel_a_n` = 0, `sel_b_n` = 0, `sel_c` = 1), `addr` and the operation are loaded (`rw_n` = 1 read, 0 write), and a new burst starts at that address.
- R3: For a read accepted at active edge E, `dq_oe` = 1 and `dq_out` holds the addressed word from active edge E+2 until active edge E+3.
- R4: For a write accepted at active edge E, the word on `dq_in` is stored at active edge E+3, and `dq_oe` stays 0 during that slot. Reads and writes may alternate on consecutive active edges with no idle cycles between them.
- R5: A read that addresses the word written by the command accepted one active edge earlier returns the merged, newly written data.
- R6: `byte_we_n[i]` = 0 writes lane i, which is `dq_in[9*i+8:9*i]`. The enables are sampled with each write command, both on loads and on burst continues, and they have no effect on reads.
- R7: With `burst_ilv` = 0, each continue cycle (`adv_ld` = 1) in an active burst issues the next address. The low two bits step through start, start+1, start+2, start+3 modulo 4. The upper bits and the operation stay as loaded, and `addr` and `rw_n` are ignored.
- R8: With `burst_ilv` = 1, the low two bits of the continue addresses are the start bits XOR 1, 2 and 3 in turn.
- R9: At an active edge with `adv_ld` = 0 and the chip not selected, no access is issued and the burst ends. The bus is not driven in that command's slot, and a later continue is a no-operation.
- R10: A continue cycle with no burst active issues no access, and the bus is not driven in its slot.
- R11: A rising edge with `clk_en_n` = 1 changes no state. The command on the inputs is ignored, no data is stored, and `dq_out` and `dq_oe` hold their values.
- R12: A rising edge with `sleep` = 1 behaves like R11 and leaves the memory contents unchanged.
- R13: `out_en_n` = 1 forces `dq_oe` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the drive of a read that is still in its slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| addr | input | ADDR_W | Word address, used on load cycles |
| adv_ld | input | 1 | 0 loads a command, 1 continues the burst |
| rw_n | input | 1 | 1 read, 0 write, sampled on load cycles |
| clk_en_n | input | 1 | Active-low clock enable |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| byte_we_n | input | LANES | Active-low per-lane write enables |
| burst_ilv | input | 1 | Burst order, 1 interleaved, 0 linear, held static |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Freezes the block and keeps the memory |
| dq_out | output | LANES*9 | Read data toward the pad |
| dq_oe | output | 1 | Pad drive enable, 0 means high impedance |
| dq_in | input | LANES*9 | Data seen on the pad |

## Verification
Every result belongs to the bus slot that opens two active edges after its command. The read word and its drive enable are due from that edge onward, and write data is taken at the third active edge. The bench keeps the accepted commands in a queue that advances only on active edges, so frozen and sleeping edges stretch a slot exactly as they stretch the design. At mid-cycle, the monitor compares the drive enable and read word against the command at the head of the queue, or presents write data for it. The reference memory is updated only when a write leaves its slot, which gives back-to-back read-after-write its expected merged value.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  localparam int BYTE_W  = 9;  // bits per byte lane
  localparam int BURST_W = 2;  // burst counter width, burst of four
  localparam int BUS_LAT = 2;  // active edges from command to bus slot

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_LOAD  = 2'd1,
    CYC_CONT  = 2'd2,
    CYC_DESEL = 2'd3
  } cyc_kind_e;

  // low address bits of a burst beat
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               ilv
  );
    burst_lo = ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              adv_ld,
  input  logic              sel,
  input  logic              rw_n,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic              iss_vld,
  output logic              iss_we,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              active
);
  logic              active_q;
  logic              we_q;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] beat_q, beat_nx;
  cyc_kind_e         kind;

  always_comb begin
    beat_nx = beat_q + BURST_W'(1);
    if (!adv_ld) kind = sel ? CYC_LOAD : CYC_DESEL;
    else         kind = active_q ? CYC_CONT : CYC_IDLE;
    iss_vld  = (kind == CYC_LOAD) || (kind == CYC_CONT);
    iss_we   = (kind == CYC_LOAD) ? !rw_n : we_q;
    iss_addr = (kind == CYC_CONT)
             ? {base_q[ADDR_W-1:BURST_W], burst_lo(base_q[BURST_W-1:0], beat_nx, burst_ilv)}
             : addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      we_q     <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (step) begin
      unique case (kind)
        CYC_LOAD: begin
          active_q <= 1'b1;
          we_q     <= !rw_n;
          base_q   <= addr;
          beat_q   <= '0;
        end
        CYC_CONT:  beat_q   <= beat_nx;
        CYC_DESEL: active_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign active = active_q;
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              in_vld,
  input  logic              in_we,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_be_n,
  output logic              head_vld,
  output logic [ADDR_W-1:0] head_addr,
  output logic              mid_vld,
  output logic              mid_we,
  output logic [ADDR_W-1:0] mid_addr,
  output logic              slot_vld,
  output logic              slot_we,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [LANES-1:0]  slot_be_n
);
  localparam int STAGES = BUS_LAT + 1;

  logic              vld_q  [STAGES];
  logic              we_q   [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [LANES-1:0]  ben_q  [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        vld_q[i]  <= 1'b0;
        we_q[i]   <= 1'b0;
        addr_q[i] <= '0;
        ben_q[i]  <= '1;
      end
    end else if (step) begin
      vld_q[0]  <= in_vld;
      we_q[0]   <= in_we;
      addr_q[0] <= in_addr;
      ben_q[0]  <= in_be_n;
      for (int i = 1; i < STAGES; i++) begin
        vld_q[i]  <= vld_q[i-1];
        we_q[i]   <= we_q[i-1];
        addr_q[i] <= addr_q[i-1];
        ben_q[i]  <= ben_q[i-1];
      end
    end
  end

  assign head_vld  = vld_q[0];
  assign head_addr = addr_q[0];
  assign mid_vld   = vld_q[BUS_LAT-1];
  assign mid_we    = we_q[BUS_LAT-1];
  assign mid_addr  = addr_q[BUS_LAT-1];
  assign slot_vld  = vld_q[BUS_LAT];
  assign slot_we   = we_q[BUS_LAT];
  assign slot_addr = addr_q[BUS_LAT];
  assign slot_be_n = ben_q[BUS_LAT];
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      step,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES-1:0]          wr_be_n,
  input  logic [LANES*BYTE_W-1:0]   wr_data,
  output logic [LANES*BYTE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;
    logic              lane_wr;

    assign lane_wr = wr_en && !wr_be_n[g];

    always_ff @(posedge clk) begin
      if (step) begin
        if (lane_wr) mem[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
        if (rd_en) begin
          // same-edge write to the same word wins over the stale array word
          if (lane_wr && (wr_addr == rd_addr)) rd_q <= wr_data[g*BYTE_W +: BYTE_W];
          else                                 rd_q <= mem[rd_addr];
        end
      end
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = rd_q;
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              rw_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic              burst_ilv,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  logic              step;
  logic              sel;
  logic              iss_vld, iss_we;
  logic [ADDR_W-1:0] iss_addr;
  logic              burst_active;
  logic              head_vld;
  logic [ADDR_W-1:0] head_addr;
  logic              mid_vld, mid_we;
  logic [ADDR_W-1:0] mid_addr;
  logic              slot_vld, slot_we;
  logic [ADDR_W-1:0] slot_addr;
  logic [LANES-1:0]  slot_be_n;
  logic [DATA_W-1:0] rd_data;

  assign step = !clk_en_n && !sleep;
  assign sel  = !sel_a_n && !sel_b_n && sel_c;

  zbt_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .step(step), .adv_ld(adv_ld), .sel(sel),
    .rw_n(rw_n), .burst_ilv(burst_ilv), .addr(addr),
    .iss_vld(iss_vld), .iss_we(iss_we), .iss_addr(iss_addr), .active(burst_active)
  );

  zbt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .step(step),
    .in_vld(iss_vld), .in_we(iss_we), .in_addr(iss_addr), .in_be_n(byte_we_n),
    .head_vld(head_vld), .head_addr(head_addr),
    .mid_vld(mid_vld), .mid_we(mid_we), .mid_addr(mid_addr),
    .slot_vld(slot_vld), .slot_we(slot_we), .slot_addr(slot_addr), .slot_be_n(slot_be_n)
  );

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .step(step),
    .rd_en(mid_vld && !mid_we), .rd_addr(mid_addr),
    .wr_en(slot_vld && slot_we), .wr_addr(slot_addr), .wr_be_n(slot_be_n),
    .wr_data(dq_in), .rd_data(rd_data)
  );

  assign dq_out = rd_data;
  assign dq_oe  = slot_vld && !slot_we && !out_en_n;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              adv_ld,
  input logic              sel,
  input logic              burst_ilv,
  input logic              burst_active,
  input logic [ADDR_W-1:0] addr,
  input logic              head_vld,
  input logic [ADDR_W-1:0] head_addr,
  input logic              slot_vld,
  input logic              slot_we,
  input logic [DATA_W-1:0] dq_out
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !adv_ld && sel) |=> (head_vld && head_addr == $past(addr)));

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && adv_ld && burst_active && !burst_ilv) |=>
      (head_vld && head_addr[1:0] == $past(head_addr[1:0]) + 2'd1
       && head_addr[ADDR_W-1:2] == $past(head_addr[ADDR_W-1:2])));

  assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !adv_ld && !sel) |=> (!head_vld && !burst_active));

  assert_idle_cont_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && adv_ld && !burst_active) |=> !head_vld);

  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(slot_vld) && $stable(slot_we) && $stable(dq_out)
               && $stable(head_vld) && $stable(burst_active)));
endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .adv_ld(adv_ld), .sel(sel),
  .burst_ilv(burst_ilv), .burst_active(burst_active), .addr(addr),
  .head_vld(head_vld), .head_addr(head_addr),
  .slot_vld(slot_vld), .slot_we(slot_we), .dq_out(dq_out)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  import zbt_sram_pkg::*;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int DW = LN * BYTE_W;
  localparam logic [DW-1:0] IDLE_BUS = DW'(32'h25A5A);

  typedef enum {K_Z, K_RD, K_WR} kind_e;
  typedef struct {
    kind_e          kind;
    logic [AW-1:0]  a;
    logic [LN-1:0]  be_n;
    logic [DW-1:0]  wd;
    string          tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          adv_ld = 1'b0, rw_n = 1'b1, clk_en_n = 1'b0;
  logic          sel_a_n = 1'b1, sel_b_n = 1'b0, sel_c = 1'b1;
  logic [LN-1:0] byte_we_n = '0;
  logic          burst_ilv = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [DW-1:0] dq_in = IDLE_BUS;

  item_t         pend;
  bit            has_pend = 0;
  item_t         acc_q[$];
  logic [DW-1:0] ref_mem [1 << AW];
  int            n_chk = 0, n_fail = 0, wseq = 0;
  bit            oe_done = 0;
  bit            b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_beat = '0;

  always #10ns clk = ~clk;  // 50 MHz

  zbt_sram #(.ADDR_W(AW), .LANES(LN)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adv_ld(adv_ld), .rw_n(rw_n),
    .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .byte_we_n(byte_we_n), .burst_ilv(burst_ilv), .out_en_n(out_en_n), .sleep(sleep),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_item(input kind_e k, input logic [AW-1:0] a,
                           input logic [LN-1:0] ben, input string tag);
    pend.kind = k;
    pend.a    = a;
    pend.be_n = ben;
    pend.tag  = tag;
    wseq++;
    pend.wd   = DW'(32'h9E3779B9 * wseq);
    has_pend  = 1;
  endtask

  task automatic set_cmd(input bit adv, input bit an, input bit bn, input bit c,
                         input bit rw, input logic [AW-1:0] a, input logic [LN-1:0] ben);
    adv_ld = adv; sel_a_n = an; sel_b_n = bn; sel_c = c;
    rw_n = rw; addr = a; byte_we_n = ben;
  endtask

  task automatic do_load(input bit wr, input logic [AW-1:0] a,
                         input logic [LN-1:0] ben, input string tag);
    @(negedge clk);
    clk_en_n = 0; sleep = 0;
    set_cmd(0, 0, 0, 1, !wr, a, ben);
    b_act = 1; b_wr = wr; b_base = a; b_beat = 0;
    push_item(wr ? K_WR : K_RD, a, ben, tag);
  endtask

  task automatic do_cont(input logic [LN-1:0] ben, input string tag);
    logic [AW-1:0] a;
    @(negedge clk);
    clk_en_n = 0; sleep = 0;
    set_cmd(1, 0, 0, 1, 0, AW'(6'h3F), ben);  // addr and rw_n are garbage here
    if (b_act) begin
      b_beat = b_beat + 2'd1;
      a = {b_base[AW-1:2], burst_ilv ? (b_base[1:0] ^ b_beat) : (b_base[1:0] + b_beat)};
      push_item(b_wr ? K_WR : K_RD, a, ben, tag);
    end else begin
      push_item(K_Z, '0, ben, tag);
    end
  endtask

  task automatic do_desel(input bit an, input bit bn, input bit c, input string tag);
    @(negedge clk);
    clk_en_n = 0; sleep = 0;
    set_cmd(0, an, bn, c, 0, AW'(8), '0);  // a write that must not happen
    b_act = 0;
    push_item(K_Z, '0, '0, tag);
  endtask

  task automatic do_freeze(input int n, input bit use_sleep, input logic [AW-1:0] a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clk_en_n = !use_sleep; sleep = use_sleep;
      set_cmd(0, 0, 0, 1, 0, a, '0);  // full write that must be ignored
    end
  endtask

  // accept commands on active edges; retire a slot when its write is captured
  always @(posedge clk) begin
    if (rst_n && !clk_en_n && !sleep) begin
      if (!has_pend) begin
        pend.kind = K_Z; pend.a = '0; pend.be_n = '1; pend.wd = '0; pend.tag = "R1";
      end
      acc_q.push_back(pend);
      has_pend = 0;
      if (acc_q.size() > BUS_LAT + 1) begin
        item_t done;
        done = acc_q.pop_front();
        if (done.kind == K_WR)
          for (int l = 0; l < LN; l++)
            if (!done.be_n[l]) ref_mem[done.a][l*BYTE_W +: BYTE_W] = done.wd[l*BYTE_W +: BYTE_W];
      end
    end
  end

  // mid-cycle bus monitor
  always @(negedge clk) begin
    item_t f;
    #2ns;
    dq_in = IDLE_BUS;
    if (!rst_n) begin
      check(dq_oe == 1'b0, "R1", "oe in reset", DW'(dq_oe), '0);
    end else if (acc_q.size() == BUS_LAT + 1) begin
      f = acc_q[0];
      case (f.kind)
        K_RD: begin
          check(dq_oe == 1'b1, f.tag, "read oe", DW'(dq_oe), DW'(1));
          check(dq_out == ref_mem[f.a], f.tag, "read data", dq_out, ref_mem[f.a]);
          if (f.tag == "R13" && !oe_done) begin
            oe_done = 1;
            out_en_n = 1'b1;
            #1ns check(dq_oe == 1'b0, "R13", "oe forced off", DW'(dq_oe), '0);
            out_en_n = 1'b0;
            #1ns check(dq_oe == 1'b1, "R13", "oe restored", DW'(dq_oe), DW'(1));
          end
        end
        K_WR: begin
          dq_in = f.wd;
          check(dq_oe == 1'b0, f.tag, "write slot not driven", DW'(dq_oe), '0);
        end
        default: check(dq_oe == 1'b0, f.tag, "idle slot not driven", DW'(dq_oe), '0);
      endcase
    end else begin
      check(dq_oe == 1'b0, "R1", "empty pipe", DW'(dq_oe), '0);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: continues with no burst active
    do_cont('0, "R10"); do_cont('0, "R10");
    // R2/R7: linear write burst 8..11, then read it back (R3)
    do_load(1, 6'd8, '0, "R2"); do_cont('0, "R7"); do_cont('0, "R7"); do_cont('0, "R7");
    do_load(0, 6'd8, '1, "R3"); do_cont('0, "R7"); do_cont('0, "R7"); do_cont('0, "R7");
    // R4 alternating, R5 read right after write to same word
    do_load(1, 6'd20, '0, "R4"); do_load(0, 6'd9, '0, "R4");
    do_load(1, 6'd21, '0, "R4"); do_load(0, 6'd21, '0, "R5"); do_load(0, 6'd20, '0, "R4");
    // R7 wrap: start low bits 2 and 1
    do_load(1, 6'd6, '0, "R7"); do_cont('0, "R7"); do_cont('0, "R7"); do_cont('0, "R7");
    do_load(0, 6'd5, '0, "R7"); do_cont('0, "R7"); do_cont('0, "R7"); do_cont('0, "R7");
    // R6 lanes, R5 merged forwarding
    do_load(1, 6'd8, 2'b10, "R6"); do_load(0, 6'd8, 2'b11, "R5");
    do_load(1, 6'd9, 2'b01, "R6"); do_cont(2'b10, "R6"); do_cont(2'b11, "R6");
    do_load(0, 6'd8, '0, "R6"); do_cont('0, "R6"); do_cont('0, "R6"); do_cont('0, "R6");
    // R9 deselect patterns
    do_load(0, 6'd8, '0, "R9"); do_cont('0, "R9"); do_desel(1, 0, 1, "R9");
    do_cont('0, "R9"); do_desel(0, 1, 1, "R9"); do_desel(0, 0, 0, "R9"); do_cont('0, "R10");
    // R11 clock enable freeze with a read, then with a write in the slot
    do_load(1, 6'd30, '0, "R11"); do_load(0, 6'd8, '0, "R11");
    do_desel(1, 0, 1, "R11"); do_desel(1, 0, 1, "R11");
    do_freeze(3, 0, 6'd30);
    do_load(0, 6'd30, '0, "R11");
    do_load(1, 6'd31, '0, "R11"); do_desel(1, 0, 1, "R11"); do_desel(1, 0, 1, "R11");
    do_freeze(2, 0, 6'd31);
    do_load(0, 6'd31, '0, "R11"); do_load(0, 6'd30, '0, "R11");
    // R12 sleep
    do_load(1, 6'd32, '0, "R12"); do_desel(1, 0, 1, "R12"); do_desel(1, 0, 1, "R12");
    do_freeze(3, 1, 6'd32);
    do_load(0, 6'd32, '0, "R12"); do_load(0, 6'd9, '0, "R12");
    // R13 asynchronous output enable
    do_load(0, 6'd9, '0, "R13");
    repeat (4) do_desel(1, 0, 1, "R13");
    // R8 interleaved order after a fresh reset
    @(negedge clk);
    rst_n = 0; burst_ilv = 1; has_pend = 0; b_act = 0;
    acc_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
    do_load(1, 6'd13, '0, "R8"); do_cont('0, "R8"); do_cont('0, "R8"); do_cont('0, "R8");
    do_load(0, 6'd14, '0, "R8"); do_cont('0, "R8"); do_cont('0, "R8"); do_cont('0, "R8");
    repeat (4) do_desel(1, 0, 1, "R9");
    finish_run();
  end
endmodule